// File: doc/BRIEF.md
# PCI Master Resource-Lock Controller

This block lives inside a PCI bus master and decides when that master may take, keep and give up exclusive ownership of the shared bus LOCK line. The master's transaction engine asks for a locked operation and says whether the first access is a read. The block watches the arbiter grant, FRAME and the bus LOCK line, and records whether another master currently holds the lock. It answers with a locked-mode indication, or with a refusal when the first access would be a write.

Once armed, the block keeps LOCK negated through the address phase of the first transaction and asserts it on the next clock. A retry on that first read drops the attempt without gaining ownership. A completed first read gives ownership, which is kept across any number of further transactions. The lock is released after the final data phase that the engine marks as the end of the operation. A grant that arrives while another master owns LOCK leaves this master with ordinary, nonexclusive access only.

All bus-side inputs and outputs are active-high "asserted" flags. Pad inversion for the active-low PCI pins happens outside the block.

Top module: `pci_lock_ctrl`

## Requirements
- R1: After a synchronous active-low reset, lock_drive, lock_mode, lock_owned and lock_refuse are all 0.
- R2: In idle, when lk_req, lk_rd and bus_gnt are 1 and the lock is free, lock_mode becomes 1 on the next clock while lock_drive stays 0.
- R3: A grant while another master holds the lock (busy) neither arms the block nor raises lock_refuse, so the master keeps nonexclusive access only.
- R4: The lock counts as busy from any clock in which bus_lock and bus_frame are both 1 and another master drives them. It stays busy until a clock in which both are 0. While busy, an otherwise valid request is not accepted.
- R5: In idle, a valid granted request with lk_rd = 0 (first access a write) gives lock_refuse = 1 in that same clock, and the block stays idle.
- R6: LOCK is kept negated (lock_drive = 0) during the armed master's address phase (addr_phase = 1). It is asserted on the following clock.
- R7: If the first locked transaction sees tx_retry = 1, lock_drive and lock_mode are 0 on the next clock and ownership is never reported.
- R8: When the first locked read finishes its final data phase (tx_last = 1, no retry, lk_end = 0), lock_owned becomes 1. lock_owned and lock_drive then stay 1 across further transactions until release.
- R9: A final data phase with lk_end = 1 while LOCK is driven returns the block to idle: all outputs are 0 on the next clock.
- R10: When tx_retry and tx_last are both 1 in the first transaction, the retry wins: there is no ownership and LOCK is released.
- R11: If lk_req falls while armed and before the address phase, the block returns to idle with LOCK never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Engine requests a locked operation |
| lk_rd | input | 1 | First access of the requested operation is a read |
| lk_end | input | 1 | Current transaction ends the locked operation |
| bus_gnt | input | 1 | Arbiter grant to this master is asserted |
| bus_frame | input | 1 | Bus FRAME is asserted |
| bus_lock | input | 1 | Bus LOCK is asserted (any driver) |
| addr_phase | input | 1 | This master's address phase is on the bus this clock |
| tx_retry | input | 1 | Current transaction terminated with retry |
| tx_last | input | 1 | Final data phase of current transaction completes |
| lock_drive | output | 1 | Drive LOCK asserted |
| lock_mode | output | 1 | Engine must issue its transaction as a locked one |
| lock_owned | output | 1 | This master owns the lock |
| lock_refuse | output | 1 | Locked request refused: first access is a write |

## Verification
Two decisions can fall in the same clock. One is a grant to this master in a cycle where another master's LOCK and FRAME appear together. The other is a retry and a final data phase reported together during the first locked read. The bench provokes both with directed sequences and also reaches them through biased random bus activity. A reference model in the bench gives the expected outcome: no arming in the first case (R3, R4), and release without ownership in the second (R10).

// File: rtl/lkc_pkg.sv
// Package: shared state type for the resource-lock controller.
package lkc_pkg;
    typedef enum logic [1:0] {
        LK_IDLE  = 2'd0,   // no locked operation
        LK_ARMED = 2'd1,   // grant taken, waiting for own address phase
        LK_FIRST = 2'd2,   // first locked read in flight, LOCK driven
        LK_OWNED = 2'd3    // lock owned across transactions
    } lk_state_e;
endpackage

// File: rtl/lkc_busy_track.sv
// Module: lkc_busy_track
// Tracks whether another master holds the bus lock. Busy is set when LOCK
// and FRAME are seen together and cleared once both are negated.
// Assumes: own_drive is 1 whenever this master drives LOCK; during that time
// the observed LOCK is this master's own and does not count as busy.
module lkc_busy_track (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_frame,
    input  logic bus_lock,
    input  logic own_drive,
    output logic busy_now
);
    logic busy_q;

    // Combinational view of busy including the current clock's bus state.
    always_comb begin
        if (own_drive)
            busy_now = 1'b0;
        else if (bus_lock && bus_frame)
            busy_now = 1'b1;
        else if (!bus_lock && !bus_frame)
            busy_now = 1'b0;
        else
            busy_now = busy_q;
    end

    // Register the busy view for the following clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= 1'b0;
        else
            busy_q <= busy_now;
    end
endmodule

// File: rtl/lkc_fsm.sv
// Module: lkc_fsm
// Lock ownership sequencer: arms on a free-lock grant for a read, keeps LOCK
// negated through the address phase, drives it from the next clock, drops on
// retry of the first read, holds ownership, and releases after the last phase.
// Assumes: addr_phase, tx_retry and tx_last come from this master's own engine.
module lkc_fsm
    import lkc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lk_req,
    input  logic lk_rd,
    input  logic lk_end,
    input  logic bus_gnt,
    input  logic busy_now,
    input  logic addr_phase,
    input  logic tx_retry,
    input  logic tx_last,
    output logic lock_drive,
    output logic lock_mode,
    output logic lock_owned,
    output logic lock_refuse
);
    lk_state_e state_q, state_d;
    logic      take_ok;

    // A granted request while the lock is free.
    assign take_ok = (state_q == LK_IDLE) && lk_req && bus_gnt && !busy_now;

    // Next-state selection; retry takes priority over completion.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_IDLE:  if (take_ok && lk_rd) state_d = LK_ARMED;
            LK_ARMED: begin
                if (!lk_req)         state_d = LK_IDLE;
                else if (addr_phase) state_d = LK_FIRST;
            end
            LK_FIRST: begin
                if (tx_retry)        state_d = LK_IDLE;
                else if (tx_last)    state_d = lk_end ? LK_IDLE : LK_OWNED;
            end
            LK_OWNED: if (tx_last && lk_end) state_d = LK_IDLE;
            default:  state_d = LK_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= LK_IDLE;
        else
            state_q <= state_d;
    end

    // Output decode from the registered state.
    always_comb begin
        lock_drive  = (state_q == LK_FIRST) || (state_q == LK_OWNED);
        lock_mode   = (state_q != LK_IDLE);
        lock_owned  = (state_q == LK_OWNED);
        lock_refuse = take_ok && !lk_rd;
    end
endmodule

// File: rtl/pci_lock_ctrl.sv
// Module: pci_lock_ctrl (top)
// Resource-lock controller for a PCI master. Combines the foreign-lock busy
// tracker with the ownership sequencer.
// Assumes: all bus flags are active-high "asserted" views of the pins.
module pci_lock_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic lk_req,
    input  logic lk_rd,
    input  logic lk_end,
    input  logic bus_gnt,
    input  logic bus_frame,
    input  logic bus_lock,
    input  logic addr_phase,
    input  logic tx_retry,
    input  logic tx_last,
    output logic lock_drive,
    output logic lock_mode,
    output logic lock_owned,
    output logic lock_refuse
);
    logic busy_now;
    logic drive_int;

    lkc_busy_track u_busy (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_frame (bus_frame),
        .bus_lock  (bus_lock),
        .own_drive (drive_int),
        .busy_now  (busy_now)
    );

    lkc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_req      (lk_req),
        .lk_rd       (lk_rd),
        .lk_end      (lk_end),
        .bus_gnt     (bus_gnt),
        .busy_now    (busy_now),
        .addr_phase  (addr_phase),
        .tx_retry    (tx_retry),
        .tx_last     (tx_last),
        .lock_drive  (drive_int),
        .lock_mode   (lock_mode),
        .lock_owned  (lock_owned),
        .lock_refuse (lock_refuse)
    );

    assign lock_drive = drive_int;
endmodule

// File: rtl/pci_lock_ctrl_chk.sv
// Module: pci_lock_ctrl_chk
// Port-level temporal checks of the lock controller, bound to the top.
module pci_lock_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic lk_req,
    input logic lk_rd,
    input logic lk_end,
    input logic bus_gnt,
    input logic bus_frame,
    input logic bus_lock,
    input logic addr_phase,
    input logic tx_retry,
    input logic tx_last,
    input logic lock_drive,
    input logic lock_mode,
    input logic lock_owned,
    input logic lock_refuse
);
    // R2: a granted read request with the bus idle arms the block.
    p_arm_on_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_mode && lk_req && lk_rd && bus_gnt && !bus_lock && !bus_frame) |=> lock_mode);

    // R3, R4: a foreign LOCK with FRAME blocks arming.
    p_busy_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_mode && bus_lock && bus_frame) |=> !lock_mode);

    // R5: a refusal leaves the block idle.
    p_refuse_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_refuse |=> !lock_mode);

    // R6: LOCK negated in the address phase, asserted on the next clock.
    p_addr_then_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_mode && !lock_drive && lk_req && addr_phase) |=> lock_drive);

    // R7, R10: retry of the first read releases without ownership.
    p_retry_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_drive && !lock_owned && tx_retry) |=> (!lock_drive && !lock_owned));

    // R8: ownership implies LOCK is driven.
    p_owned_drives_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_owned |-> lock_drive);

    // R9: final phase with end releases LOCK.
    p_end_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_owned && tx_last && lk_end) |=> (!lock_drive && !lock_mode));

    // R11: withdrawing the request while armed returns to idle.
    p_withdraw_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_mode && !lock_drive && !lk_req) |=> !lock_mode);
endmodule

bind pci_lock_ctrl pci_lock_ctrl_chk u_chk (.*);

// File: tb/sim_pci_lock_ctrl.sv
// Bench: reference model, random bus activity with a fixed seed, plus
// directed corner cases.
module sim_pci_lock_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_req = 0, lk_rd = 0, lk_end = 0, bus_gnt = 0, bus_frame = 0;
    logic ext_lock = 0, addr_phase = 0, tx_retry = 0, tx_last = 0;
    logic bus_lock;
    logic lock_drive, lock_mode, lock_owned, lock_refuse;
    int   checks = 0;
    int   fails  = 0;
    int   m_st   = 0;   // 0 idle, 1 armed, 2 first, 3 owned
    bit   m_busy = 0;

    always #10 clk = ~clk;   // 50 MHz

    assign bus_lock = ext_lock | lock_drive;

    pci_lock_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_rd(lk_rd), .lk_end(lk_end),
        .bus_gnt(bus_gnt), .bus_frame(bus_frame), .bus_lock(bus_lock),
        .addr_phase(addr_phase), .tx_retry(tx_retry), .tx_last(tx_last),
        .lock_drive(lock_drive), .lock_mode(lock_mode), .lock_owned(lock_owned),
        .lock_refuse(lock_refuse)
    );

    function automatic bit f_drive(int st);
        return (st == 2) || (st == 3);
    endfunction

    function automatic bit f_busy_now(int st, bit b, bit lk, bit fr);
        if (f_drive(st)) return 1'b0;
        if (lk && fr)    return 1'b1;
        if (!lk && !fr)  return 1'b0;
        return b;
    endfunction

    function automatic bit f_take(int st, bit b, bit lk, bit fr, bit rq, bit g);
        return (st == 0) && rq && g && !f_busy_now(st, b, lk, fr);
    endfunction

    function automatic int f_next(int st, bit b, bit lk, bit fr);
        case (st)
            0: return (f_take(st, b, lk, fr, lk_req, bus_gnt) && lk_rd) ? 1 : 0;
            1: return !lk_req ? 0 : (addr_phase ? 2 : 1);
            2: return tx_retry ? 0 : (tx_last ? (lk_end ? 0 : 3) : 2);
            default: return (tx_last && lk_end) ? 0 : 3;
        endcase
    endfunction

    task automatic chk1(string tag, string nm, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, nm, act, exp, $time);
        end
    endtask

    // Check all outputs against the model mid-cycle, then advance the model.
    task automatic tick(string tag);
        bit bl;
        @(negedge clk);
        bl = bus_lock;
        if (!rst_n) begin
            m_st = 0; m_busy = 0;
        end
        chk1(tag, "lock_drive",  lock_drive,  f_drive(m_st));
        chk1(tag, "lock_mode",   lock_mode,   m_st != 0);
        chk1(tag, "lock_owned",  lock_owned,  m_st == 3);
        chk1(tag, "lock_refuse", lock_refuse,
             rst_n && f_take(m_st, m_busy, bl, bus_frame, lk_req, bus_gnt) && !lk_rd);
        @(posedge clk);
        if (rst_n) begin
            int nx;
            nx     = f_next(m_st, m_busy, bl, bus_frame);
            m_busy = f_busy_now(m_st, m_busy, bl, bus_frame);
            m_st   = nx;
        end
        #1;
    endtask

    task automatic quiet();
        lk_req = 0; lk_rd = 0; lk_end = 0; bus_gnt = 0; bus_frame = 0;
        ext_lock = 0; addr_phase = 0; tx_retry = 0; tx_last = 0;
    endtask

    // Take the lock with a read and run the first address phase.
    task automatic arm_and_start(string tag);
        quiet(); lk_req = 1; lk_rd = 1; bus_gnt = 1;
        tick(tag);
        bus_gnt = 0; addr_phase = 1; bus_frame = 1;
        tick(tag);
        addr_phase = 0;
    endtask

    initial begin : watchdog
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        quiet();
        rst_n = 0;
        tick("R1 reset"); tick("R1 reset");
        rst_n = 1;
        tick("R1 after reset");

        // R2 + R6 + R8 + R9: full locked operation over two transactions.
        arm_and_start("R2 R6 arm/address");
        bus_frame = 1; tx_last = 1;
        tick("R6 first data");
        tx_last = 0; bus_frame = 0;
        tick("R8 owned between transactions");
        bus_frame = 1; addr_phase = 1;
        tick("R8 second address");
        addr_phase = 0; tx_last = 1; lk_end = 1;
        tick("R9 final phase");
        quiet();
        tick("R9 released");

        // R5: write as first access refused.
        lk_req = 1; lk_rd = 0; bus_gnt = 1;
        tick("R5 write refused");
        quiet();
        tick("R5 stays idle");

        // R3/R4: foreign lock blocks, persists until both negated.
        ext_lock = 1; bus_frame = 1; lk_req = 1; lk_rd = 1; bus_gnt = 1;
        tick("R3 grant with foreign lock");
        bus_frame = 0;
        tick("R4 still busy lock only");
        ext_lock = 0; bus_frame = 1;
        tick("R4 still busy frame only");
        bus_frame = 0;
        tick("R4 free again");
        quiet();
        tick("R4 armed after free");
        lk_req = 0;
        tick("R11 withdraw");
        quiet();
        tick("R11 idle");

        // R7: retry on the first read.
        arm_and_start("R7 arm");
        tx_retry = 1;
        tick("R7 retry");
        quiet();
        tick("R7 released");

        // R10: retry and last together.
        arm_and_start("R10 arm");
        tx_retry = 1; tx_last = 1;
        tick("R10 retry wins");
        quiet();
        tick("R10 released");

        // Random mix with reference model.
        for (int i = 0; i < 4000; i++) begin
            lk_req     = ($urandom_range(0, 9) < 7);
            lk_rd      = ($urandom_range(0, 9) < 7);
            lk_end     = ($urandom_range(0, 9) < 3);
            bus_gnt    = ($urandom_range(0, 9) < 4);
            bus_frame  = ($urandom_range(0, 9) < 4);
            ext_lock   = ($urandom_range(0, 9) < 2) && !lock_drive;
            addr_phase = ($urandom_range(0, 9) < 4);
            tx_retry   = ($urandom_range(0, 9) < 2);
            tx_last    = ($urandom_range(0, 9) < 4);
            tick("R2 R3 R5 R6 R7 R8 R9 R10 random");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule